// File: doc/BRIEF.md
# Sequential Unsigned Multiply and Divide Unit

This unit runs one of three unsigned operations per request. The first is a half-width multiply that yields a full-width product. The second is a full-width integer divide that yields a quotient and a remainder. The third is a full-width fractional divide whose quotient is the numerator scaled up by 2^W and divided by the denominator. The divides use a restoring shift-and-subtract loop that settles one quotient bit per clock. The multiply uses a shift-and-add loop that handles one multiplier bit per clock.

Operands are presented on input ports together with a one-cycle `start`. The unit raises `busy` while it works and pulses `done` for one cycle when the results are on the outputs. Results and flags then stay where they are until the next operation finishes. Quotients go to `quo_out` and remainders go to `acc_out`. The multiply places its product on `acc_out` and leaves `quo_out` untouched. Three flags report the outcome: `flag_z` for a zero result, `flag_c` for division by zero or for the multiply rounding bit, and `flag_v` for a fractional overflow.

Top module: `muldiv_unit`

## Requirements
- R1: `start` is accepted only while the unit is idle, which is any cycle with `busy` low, including the cycle in which `done` is high. A `start` held or pulsed while `busy` is high is ignored: it changes no result and adds no `done` pulse.
- R2: `busy` rises in the cycle after an accepted `start`. It stays high for 9 cycles for a multiply, 17 cycles for a divide that iterates, and 1 cycle for a divide that finishes early. `done` is high for exactly one cycle directly after `busy` falls, and never together with `busy`.
- R3: `op_sel` = 2'b00 selects multiply. `acc_out` becomes `mul_a` × `mul_b` (both W/2-bit unsigned), and `quo_out` keeps its previous value.
- R4: `op_sel` = 2'b01 selects integer divide with a nonzero `den_in`. `quo_out` becomes floor(`num_in`/`den_in`) and `acc_out` becomes `num_in` mod `den_in`.
- R5: `op_sel` = 2'b10 or 2'b11 selects fractional divide with `num_in` < `den_in`. `quo_out` becomes floor(`num_in`·2^W/`den_in`) and `acc_out` becomes (`num_in`·2^W) mod `den_in`.
- R6: A divide of either kind with `den_in` = 0 sets `flag_c` = 1, returns `quo_out` = all ones and `acc_out` = `num_in`, and finishes without iterating.
- R7: A fractional divide with `num_in` ≥ `den_in` sets `flag_v` = 1, returns all ones and `num_in` as in R6, and finishes without iterating. Integer divide and multiply always clear `flag_v`.
- R8: `flag_z` is 1 exactly when the new quotient is zero. For a multiply it is 1 exactly when the product is zero.
- R9: A multiply sets `flag_c` to bit W/2−1 of the product. A divide with a nonzero denominator clears `flag_c`.
- R10: After reset, `busy`, `done`, `quo_out`, `acc_out` and all three flags are zero.
- R11: Between completions, `quo_out`, `acc_out` and the flags hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request an operation (sampled when idle) |
| op_sel | input | 2 | 00 multiply, 01 integer divide, 1x fractional divide |
| mul_a | input | W/2 | Multiplicand |
| mul_b | input | W/2 | Multiplier |
| num_in | input | W | Dividend |
| den_in | input | W | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quo_out | output | W | Quotient |
| acc_out | output | W | Remainder or product |
| flag_z | output | 1 | Zero result |
| flag_v | output | 1 | Fractional overflow |
| flag_c | output | 1 | Division by zero, or multiply rounding bit |

## Verification
The hardest case to reach is a `start` that arrives while the unit is still busy, or exactly in the `done` cycle. In the `done` cycle the unit is already idle again and must accept the request. The bench covers this by holding `start` high for a long stretch while it changes the operands every cycle, so that requests fall into every phase of several back-to-back operations. The two early-exit paths need operands chosen on purpose: a zero denominator, and a fractional numerator equal to or above the denominator. Randomly drawn operands would almost never hit them, so directed cases cover both, and biased random draws cover the fractional range.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WRAP = 2'd2
  } seq_state_t;

  typedef enum logic [1:0] {
    K_MUL  = 2'd0,
    K_IDIV = 2'd1,
    K_FDIV = 2'd2
  } op_kind_t;

  function automatic op_kind_t decode_op(input logic [1:0] code);
    op_kind_t k;
    if (code == 2'b00)      k = K_MUL;
    else if (code == 2'b01) k = K_IDIV;
    else                    k = K_FDIV;
    return k;
  endfunction

endpackage

// File: rtl/muldiv_seq.sv
module muldiv_seq
  import muldiv_pkg::*;
#(
  parameter int unsigned W  = 16,
  parameter int unsigned MW = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic [1:0]  op_sel,
  input  logic [W-1:0] num_in,
  input  logic [W-1:0] den_in,
  output op_kind_t    kind_now,
  output op_kind_t    kind_q,
  output logic        early,
  output logic        dz_q,
  output logic        ov_q,
  output logic        load_en,
  output logic        step_en,
  output logic        wrap_en,
  output logic        busy,
  output logic        done
);
  localparam int unsigned CW = $clog2(W + 1);
  localparam logic [CW-1:0] DIV_LAST = CW'(W - 1);
  localparam logic [CW-1:0] MUL_LAST = CW'(MW - 1);

  seq_state_t    state;
  logic [CW-1:0] cnt;
  logic          div_by_zero;
  logic          frac_ovf;
  logic          done_q;

  assign kind_now    = decode_op(op_sel);
  assign div_by_zero = (kind_now != K_MUL) && (den_in == '0);
  assign frac_ovf    = (kind_now == K_FDIV) && (num_in >= den_in);
  assign early       = div_by_zero | frac_ovf;
  assign load_en     = go && (state == ST_IDLE);
  assign step_en     = (state == ST_RUN);
  assign wrap_en     = (state == ST_WRAP);
  assign busy        = (state != ST_IDLE);
  assign done        = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      kind_q <= K_MUL;
      dz_q   <= 1'b0;
      ov_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= wrap_en;
      case (state)
        ST_IDLE: begin
          if (load_en) begin
            kind_q <= kind_now;
            dz_q   <= div_by_zero;
            ov_q   <= frac_ovf;
            cnt    <= (kind_now == K_MUL) ? MUL_LAST : DIV_LAST;
            state  <= early ? ST_WRAP : ST_RUN;
          end
        end
        ST_RUN: begin
          if (cnt == '0) state <= ST_WRAP;
          else           cnt   <= cnt - CW'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r2_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && cnt != '0) |=> (step_en && cnt == $past(cnt) - CW'(1)));

  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  a_r2_busy_done_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done_q));

  a_r1_kind_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(kind_q) && $stable(dz_q) && $stable(ov_q)));

  a_r6_zero_den_skips: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && div_by_zero) |=> wrap_en);

  a_r7_ovf_skips: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && frac_ovf) |=> wrap_en);

endmodule

// File: rtl/muldiv_core.sv
module muldiv_core
  import muldiv_pkg::*;
#(
  parameter int unsigned W  = 16,
  parameter int unsigned MW = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic         step_en,
  input  logic         early,
  input  op_kind_t     kind_now,
  input  op_kind_t     kind_q,
  input  logic [MW-1:0] mul_a,
  input  logic [MW-1:0] mul_b,
  input  logic [W-1:0] num_in,
  input  logic [W-1:0] den_in,
  output logic [W-1:0] quot_raw,
  output logic [W-1:0] rem_raw
);
  typedef struct packed {
    logic [W-1:0] rem;
    logic         qbit;
  } dstep_t;

  function automatic dstep_t div_step(input logic [W-1:0] r, input logic sin,
                                      input logic [W-1:0] d);
    logic [W:0] sh;
    dstep_t     o;
    sh = {r, sin};
    if (sh >= {1'b0, d}) begin
      o.rem  = W'(sh - {1'b0, d});
      o.qbit = 1'b1;
    end else begin
      o.rem  = sh[W-1:0];
      o.qbit = 1'b0;
    end
    return o;
  endfunction

  function automatic logic [W-1:0] mul_acc(input logic [W-1:0] acc,
                                           input logic [W-1:0] mc, input logic take);
    return take ? acc + mc : acc;
  endfunction

  logic [W-1:0] part_r;
  logic [W-1:0] part_q;
  logic [W-1:0] dsr;
  logic         shift_in;
  dstep_t       nxt;

  assign shift_in = (kind_q == K_IDIV) ? part_q[W-1] : 1'b0;
  assign nxt      = div_step(part_r, shift_in, dsr);
  assign quot_raw = part_q;
  assign rem_raw  = part_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part_r <= '0;
      part_q <= '0;
      dsr    <= '0;
    end else if (load_en) begin
      dsr <= den_in;
      if (early) begin
        part_r <= num_in;
        part_q <= '1;
      end else begin
        case (kind_now)
          K_MUL: begin
            part_r <= '0;
            part_q <= {{(W-MW){1'b0}}, mul_b};
            dsr    <= {{(W-MW){1'b0}}, mul_a};
          end
          K_IDIV: begin
            part_r <= '0;
            part_q <= num_in;
          end
          default: begin
            part_r <= num_in;
            part_q <= '0;
          end
        endcase
      end
    end else if (step_en) begin
      if (kind_q == K_MUL) begin
        part_r <= mul_acc(part_r, dsr, part_q[0]);
        part_q <= part_q >> 1;
        dsr    <= dsr << 1;
      end else begin
        part_r <= nxt.rem;
        part_q <= {part_q[W-2:0], nxt.qbit};
      end
    end
  end

  a_r4_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && kind_q != K_MUL) |=> (part_r < dsr));

  a_r5_divisor_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && kind_q != K_MUL) |=> $stable(dsr));

endmodule

// File: rtl/muldiv_out.sv
module muldiv_out
  import muldiv_pkg::*;
#(
  parameter int unsigned W  = 16,
  parameter int unsigned MW = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wrap_en,
  input  op_kind_t     kind_q,
  input  logic         dz_q,
  input  logic         ov_q,
  input  logic [W-1:0] quot_raw,
  input  logic [W-1:0] rem_raw,
  output logic [W-1:0] quo_out,
  output logic [W-1:0] acc_out,
  output logic         flag_z,
  output logic         flag_v,
  output logic         flag_c
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_out <= '0;
      acc_out <= '0;
      flag_z  <= 1'b0;
      flag_v  <= 1'b0;
      flag_c  <= 1'b0;
    end else if (wrap_en) begin
      acc_out <= rem_raw;
      if (kind_q == K_MUL) begin
        flag_z <= (rem_raw == '0);
        flag_c <= rem_raw[MW-1];
        flag_v <= 1'b0;
      end else begin
        quo_out <= quot_raw;
        flag_z  <= (quot_raw == '0);
        flag_c  <= dz_q;
        flag_v  <= ov_q;
      end
    end
  end

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_en |=> ($stable(quo_out) && $stable(acc_out) &&
                  $stable(flag_z) && $stable(flag_v) && $stable(flag_c)));

  a_r6_zero_den_result: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_en && dz_q) |=> (flag_c && quo_out == '1 && !flag_z));

  a_r7_idiv_clears_v: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_en && kind_q == K_IDIV) |=> !flag_v);

  a_r3_mul_keeps_quo: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_en && kind_q == K_MUL) |=> $stable(quo_out));

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       op_sel,
  input  logic [W/2-1:0]   mul_a,
  input  logic [W/2-1:0]   mul_b,
  input  logic [W-1:0]     num_in,
  input  logic [W-1:0]     den_in,
  output logic             busy,
  output logic             done,
  output logic [W-1:0]     quo_out,
  output logic [W-1:0]     acc_out,
  output logic             flag_z,
  output logic             flag_v,
  output logic             flag_c
);
  localparam int unsigned MW = W / 2;

  op_kind_t     kind_now;
  op_kind_t     kind_q;
  logic         early;
  logic         dz_q;
  logic         ov_q;
  logic         load_en;
  logic         step_en;
  logic         wrap_en;
  logic [W-1:0] quot_raw;
  logic [W-1:0] rem_raw;

  muldiv_seq #(.W(W), .MW(MW)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(start), .op_sel(op_sel),
    .num_in(num_in), .den_in(den_in),
    .kind_now(kind_now), .kind_q(kind_q), .early(early),
    .dz_q(dz_q), .ov_q(ov_q), .load_en(load_en), .step_en(step_en),
    .wrap_en(wrap_en), .busy(busy), .done(done)
  );

  muldiv_core #(.W(W), .MW(MW)) u_core (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .step_en(step_en),
    .early(early), .kind_now(kind_now), .kind_q(kind_q),
    .mul_a(mul_a), .mul_b(mul_b), .num_in(num_in), .den_in(den_in),
    .quot_raw(quot_raw), .rem_raw(rem_raw)
  );

  muldiv_out #(.W(W), .MW(MW)) u_out (
    .clk(clk), .rst_n(rst_n), .wrap_en(wrap_en), .kind_q(kind_q),
    .dz_q(dz_q), .ov_q(ov_q), .quot_raw(quot_raw), .rem_raw(rem_raw),
    .quo_out(quo_out), .acc_out(acc_out),
    .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
  );

endmodule

// File: tb/test_muldiv_unit.sv
`timescale 1ns/1ps
module test_muldiv_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op_sel = 2'b00;
  logic [7:0]  mul_a = '0, mul_b = '0;
  logic [15:0] num_in = '0, den_in = '0;
  logic        busy, done, flag_z, flag_v, flag_c;
  logic [15:0] quo_out, acc_out;

  always #2 clk = ~clk;

  muldiv_unit #(.W(16)) i_muldiv_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
    .mul_a(mul_a), .mul_b(mul_b), .num_in(num_in), .den_in(den_in),
    .busy(busy), .done(done), .quo_out(quo_out), .acc_out(acc_out),
    .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  string hs_tag = "R2";

  // behavioural reference model
  int          m_left = 0;
  bit          m_done = 0;
  logic [15:0] m_quo = '0, m_acc = '0, p_quo = '0, p_acc = '0;
  bit          m_z = 0, m_v = 0, m_c = 0, p_z = 0, p_v = 0, p_c = 0;
  bit          p_mul = 0, m_mul = 0;
  string       m_tag = "R10", p_tag = "R10";

  task automatic predict();
    longint n, d, x;
    n = num_in; d = den_in;
    p_mul = (op_sel == 2'b00);
    if (op_sel == 2'b00) begin
      x = longint'(mul_a) * longint'(mul_b);
      p_acc = x[15:0]; p_quo = m_quo; p_z = (x == 0); p_c = x[7]; p_v = 0;
      m_left = 9; p_tag = "R3";
    end else if (d == 0) begin
      p_quo = 16'hFFFF; p_acc = num_in; p_z = 0; p_c = 1; p_v = (op_sel != 2'b01);
      m_left = 1; p_tag = "R6";
    end else if (op_sel != 2'b01 && n >= d) begin
      p_quo = 16'hFFFF; p_acc = num_in; p_z = 0; p_c = 0; p_v = 1;
      m_left = 1; p_tag = "R7";
    end else if (op_sel == 2'b01) begin
      x = n / d; p_quo = x[15:0]; x = n % d; p_acc = x[15:0];
      p_z = (p_quo == 0); p_c = 0; p_v = 0; m_left = 17; p_tag = "R4";
    end else begin
      x = (n * 65536) / d; p_quo = x[15:0];
      x = (n * 65536) % d; p_acc = x[15:0];
      p_z = (p_quo == 0); p_c = 0; p_v = 0; m_left = 17; p_tag = "R5";
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_left = 0; m_done = 0; m_quo = '0; m_acc = '0;
      m_z = 0; m_v = 0; m_c = 0; m_tag = "R10";
    end else begin
      m_done = 0;
      if (m_left == 0) begin
        if (start) predict();
      end else begin
        m_left--;
        if (m_left == 0) begin
          m_done = 1; m_quo = p_quo; m_acc = p_acc;
          m_z = p_z; m_v = p_v; m_c = p_c; m_tag = p_tag; m_mul = p_mul;
        end
      end
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  // compare against the model on every cycle, away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      string ot;
      ot = m_done ? m_tag : "R11";
      chk(hs_tag, "busy", {31'd0, busy}, {31'd0, m_left > 0});
      chk(hs_tag, "done", {31'd0, done}, {31'd0, m_done});
      chk(ot, "quo_out", {16'd0, quo_out}, {16'd0, m_quo});
      chk(ot, "acc_out", {16'd0, acc_out}, {16'd0, m_acc});
      chk(m_done ? "R8" : "R11", "flag_z", {31'd0, flag_z}, {31'd0, m_z});
      chk(m_done ? "R7" : "R11", "flag_v", {31'd0, flag_v}, {31'd0, m_v});
      chk(m_done ? (m_mul ? "R9" : m_tag) : "R11", "flag_c",
          {31'd0, flag_c}, {31'd0, m_c});
    end
  end

  task automatic summary_and_end();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      summary_and_end();
    end
  end

  task automatic run_op(input logic [1:0] op, input logic [7:0] a, input logic [7:0] b,
                        input logic [15:0] n, input logic [15:0] d);
    @(negedge clk);
    while (busy) @(negedge clk);
    op_sel = op; mul_a = a; mul_b = b; num_in = n; den_in = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 40 && !done; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state seen at the ports while reset is held
    chk("R10", "busy", {31'd0, busy}, 32'd0);
    chk("R10", "done", {31'd0, done}, 32'd0);
    chk("R10", "quo_out", {16'd0, quo_out}, 32'd0);
    chk("R10", "acc_out", {16'd0, acc_out}, 32'd0);
    chk("R10", "flags", {29'd0, flag_z, flag_v, flag_c}, 32'd0);
    rst_n = 1'b1;

    // R3, R8, R9: multiply corners
    run_op(2'b00, 8'h00, 8'h5A, 16'h0, 16'h0);
    run_op(2'b00, 8'hFF, 8'hFF, 16'h0, 16'h0);
    run_op(2'b00, 8'h0F, 8'h11, 16'h0, 16'h0);
    run_op(2'b00, 8'h03, 8'h2B, 16'h0, 16'h0);
    // R4, R8: integer divide
    run_op(2'b01, 8'h0, 8'h0, 16'd1000, 16'd7);
    run_op(2'b01, 8'h0, 8'h0, 16'd5, 16'd10);
    run_op(2'b01, 8'h0, 8'h0, 16'hFFFF, 16'd1);
    run_op(2'b01, 8'h0, 8'h0, 16'hFFFF, 16'hFFFF);
    // R3: multiply leaves quotient alone after a divide
    run_op(2'b00, 8'h12, 8'h34, 16'h0, 16'h0);
    // R6: zero divisor, both kinds
    run_op(2'b01, 8'h0, 8'h0, 16'h1234, 16'h0);
    run_op(2'b10, 8'h0, 8'h0, 16'h0003, 16'h0);
    // R5: fractional divide
    run_op(2'b10, 8'h0, 8'h0, 16'd1, 16'd3);
    run_op(2'b11, 8'h0, 8'h0, 16'h7FFF, 16'h8000);
    run_op(2'b10, 8'h0, 8'h0, 16'hFFFE, 16'hFFFF);
    run_op(2'b10, 8'h0, 8'h0, 16'h0, 16'h0009);
    // R7: fractional overflow
    run_op(2'b10, 8'h0, 8'h0, 16'd5, 16'd5);
    run_op(2'b11, 8'h0, 8'h0, 16'd9, 16'd4);

    // R1: start held high through several operations, operands changing
    hs_tag = "R1";
    @(negedge clk);
    start = 1'b1;
    for (int i = 0; i < 60; i++) begin
      op_sel = 2'($urandom_range(0, 3));
      mul_a  = 8'($urandom);
      mul_b  = 8'($urandom);
      den_in = 16'($urandom_range(0, 65535));
      num_in = (i % 3 == 0) ? 16'($urandom) : 16'($urandom_range(0, 300));
      @(negedge clk);
    end
    start = 1'b0;
    for (int i = 0; i < 25; i++) @(negedge clk);
    hs_tag = "R2";

    // random mix
    for (int k = 0; k < 60; k++) begin
      logic [1:0]  op;
      logic [15:0] d, n;
      op = 2'($urandom_range(0, 3));
      d  = (k % 11 == 0) ? 16'h0 : 16'($urandom_range(1, 65535));
      n  = 16'($urandom);
      if (op[1] && (k % 4 != 0) && d != 0) n = 16'($urandom_range(0, int'(d) - 1));
      run_op(op, 8'($urandom), 8'($urandom), n, d);
    end

    repeat (4) @(negedge clk);
    summary_and_end();
  end

endmodule